// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Sequencer

This block feeds instructions to the execute stage of a small 8-bit processor that keeps its program store apart from its data store. It owns the program counter and drives the address and read enable of a synchronous, 14-bit-wide program memory. It hands one instruction word to the execute stage per instruction cycle. Because the program memory has its own bus, the fetch never waits on a data access. While the execute stage works on the current word, the word after it is already being read.

An instruction cycle is `CLKS_PER_CYC` input clocks long (four by default). A one-clock strobe marks the last clock of each cycle, and the execute stage commits its results there. At that boundary the execute stage may request a branch to a target address. When the branch is taken, the prefetched word is discarded and a NOP bubble takes its slot. Fetching then resumes at the target, so a taken branch costs one extra cycle.

The instruction output is a valid/ready stream that is sampled only at the cycle boundary. A word with `insn_valid` high moves on only if `insn_ready` is high at the strobe. If `insn_ready` is low at the strobe, the fetch sequencer holds the word, the program counter and the read address for another whole cycle. A bubble (`insn_valid` low) never waits for `insn_ready`.

Top module: `ifetch_seq`

## Requirements
- R1: While `rst_n` is low and immediately after it rises, `pm_addr` is 0, `insn` is the NOP word 14'h0000, and `insn_valid` is 0.
- R2: `cyc_strobe` is high for exactly one clock in every `CLKS_PER_CYC` clocks. It is high in the last clock of each instruction cycle, and the first cycle after reset starts on the first clock with `rst_n` high.
- R3: `pm_rd_en` is high only in the first clock of each instruction cycle. `pm_addr` changes only on the clock edge that ends a cycle.
- R4: At a cycle end with no branch and no stall, `insn` takes the word that memory returned for `pm_addr`, `insn_valid` becomes 1, and `pm_addr` advances by one.
- R5: The program counter is `PC_W` bits wide and wraps from 2^PC_W-1 to 0.
- R6: If `br_req` is high at a cycle end and the current word is valid and accepted, the next cycle presents NOP with `insn_valid`=0 and fetches from `br_target`. The word at `br_target` is presented in the cycle after that.
- R7: If `insn_valid`=1 and `insn_ready`=0 at a cycle end, `insn`, `insn_valid` and `pm_addr` are held for another cycle and `br_req` is ignored.
- R8: `insn` changes only on the clock edge that ends an instruction cycle.
- R9: While `insn_valid`=0, both `insn_ready` and `br_req` are ignored, and the fetched word is loaded at the cycle end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_req | input | 1 | Branch request, sampled at a cycle end |
| br_target | input | PC_W | Branch target address |
| insn_ready | input | 1 | Execute stage accepts the presented word |
| pm_rdata | input | 14 | Program memory read data, one clock after an enabled read |
| pm_addr | output | PC_W | Program memory address (the program counter) |
| pm_rd_en | output | 1 | Program memory read enable |
| insn | output | 14 | Instruction word presented to execute |
| insn_valid | output | 1 | High for a fetched word, low for a bubble |
| cyc_strobe | output | 1 | Last clock of the instruction cycle |

## Verification
The assertions assume that the program memory registers its read data on the clock edge where `pm_rd_en` is high, and that it holds that data until the next enabled read. They also assume that the execute stage holds `br_req`, `br_target` and `insn_ready` steady across the strobe clock. The bench's memory model returns 14'h2000 plus the address one clock after each enabled read, so every word is non-zero and tells which address it came from. The bench changes its inputs only on the falling edge at the strobe and releases `br_req` one cycle later.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam int INSN_W = 14;
  typedef logic [INSN_W-1:0] insn_t;
  localparam insn_t NOP_WORD = '0;
endpackage

// File: rtl/ifs_phase.sv
module ifs_phase #(
  parameter int CLKS_PER_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic first,
  output logic last
);
  localparam int PH_W = (CLKS_PER_CYC > 2) ? $clog2(CLKS_PER_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_CYC - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)            phase <= '0;
    else if (phase == PH_LAST) phase <= '0;
    else                   phase <= phase + 1'b1;
  end

  assign first = (phase == '0);
  assign last  = (phase == PH_LAST);
endmodule

// File: rtl/ifs_pc.sv
module ifs_pc #(
  parameter int PC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            jump,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (!rst_n)     pc <= '0;
    else if (step) begin
      if (jump) pc <= target;
      else      pc <= pc + 1'b1;
    end
  end
endmodule

// File: rtl/ifs_ir.sv
module ifs_ir
  import ifs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  flush,
  input  insn_t word,
  output insn_t ir,
  output logic  ir_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir       <= NOP_WORD;
      ir_valid <= 1'b0;
    end else if (load) begin
      ir       <= flush ? NOP_WORD : word;
      ir_valid <= !flush;
    end
  end
endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
  import ifs_pkg::*;
#(
  parameter int PC_W         = 10,
  parameter int CLKS_PER_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_req,
  input  logic [PC_W-1:0]   br_target,
  input  logic              insn_ready,
  input  logic [INSN_W-1:0] pm_rdata,
  output logic [PC_W-1:0]   pm_addr,
  output logic              pm_rd_en,
  output logic [INSN_W-1:0] insn,
  output logic              insn_valid,
  output logic              cyc_strobe
);
  logic first, last;
  logic stall, advance, taken;

  ifs_phase #(.CLKS_PER_CYC(CLKS_PER_CYC)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .first (first),
    .last  (last)
  );

  // a valid word the execute stage refuses keeps the whole pipe in place
  assign stall   = insn_valid && !insn_ready;
  assign advance = last && !stall;
  // only a real instruction can branch; bubbles ignore br_req
  assign taken   = advance && insn_valid && br_req;

  ifs_pc #(.PC_W(PC_W)) u_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (advance),
    .jump   (taken),
    .target (br_target),
    .pc     (pm_addr)
  );

  ifs_ir u_ir (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (advance),
    .flush    (taken),
    .word     (pm_rdata),
    .ir       (insn),
    .ir_valid (insn_valid)
  );

  assign pm_rd_en   = first;
  assign cyc_strobe = last;
endmodule

// File: rtl/ifetch_seq_chk.sv
module ifetch_seq_chk
  import ifs_pkg::*;
#(
  parameter int PC_W         = 10,
  parameter int CLKS_PER_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_req,
  input logic [PC_W-1:0]   br_target,
  input logic              insn_ready,
  input logic [INSN_W-1:0] pm_rdata,
  input logic [PC_W-1:0]   pm_addr,
  input logic              pm_rd_en,
  input logic [INSN_W-1:0] insn,
  input logic              insn_valid,
  input logic              cyc_strobe
);
  localparam int CW = $clog2(CLKS_PER_CYC + 1);
  logic [CW-1:0]   cnt;
  logic [PC_W-1:0] nxt;

  always_ff @(posedge clk) begin
    if (!rst_n || cyc_strobe) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
  assign nxt = pm_addr + 1'b1;

  // R2
  p_strobe_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(CLKS_PER_CYC - 1)) == cyc_strobe);
  // R3
  p_rden_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd_en |-> (cnt == '0) && !cyc_strobe);
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_strobe |=> $stable(pm_addr));
  // R4 and R5 (nxt wraps by width)
  p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && insn_valid && insn_ready && !br_req)
      |=> insn_valid && pm_addr == $past(nxt) && insn == $past(pm_rdata));
  // R6
  p_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && insn_valid && insn_ready && br_req)
      |=> !insn_valid && insn == NOP_WORD && pm_addr == $past(br_target));
  // R7
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && insn_valid && !insn_ready)
      |=> insn_valid && $stable(insn) && $stable(pm_addr));
  // R8
  p_insn_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_strobe |=> $stable(insn) && $stable(insn_valid));
  // R9
  p_bubble_nostall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && !insn_valid)
      |=> insn_valid && pm_addr == $past(nxt) && insn == $past(pm_rdata));
endmodule

bind ifetch_seq ifetch_seq_chk #(.PC_W(PC_W), .CLKS_PER_CYC(CLKS_PER_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .br_req     (br_req),
  .br_target  (br_target),
  .insn_ready (insn_ready),
  .pm_rdata   (pm_rdata),
  .pm_addr    (pm_addr),
  .pm_rd_en   (pm_rd_en),
  .insn       (insn),
  .insn_valid (insn_valid),
  .cyc_strobe (cyc_strobe)
);

// File: tb/ifetch_seq_bench.sv
`timescale 1ns/1ps
module ifetch_seq_bench;
  localparam int PC_W = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            br_req = 1'b0;
  logic [PC_W-1:0] br_target = '0;
  logic            insn_ready = 1'b1;
  logic [13:0]     pm_rdata = '0;
  logic [PC_W-1:0] pm_addr;
  logic            pm_rd_en;
  logic [13:0]     insn;
  logic            insn_valid;
  logic            cyc_strobe;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ifetch_seq #(.PC_W(PC_W), .CLKS_PER_CYC(4)) u_ifetch_seq (
    .clk(clk), .rst_n(rst_n), .br_req(br_req), .br_target(br_target),
    .insn_ready(insn_ready), .pm_rdata(pm_rdata), .pm_addr(pm_addr),
    .pm_rd_en(pm_rd_en), .insn(insn), .insn_valid(insn_valid),
    .cyc_strobe(cyc_strobe)
  );

  // program memory model: word = 14'h2000 + address
  always_ff @(posedge clk) if (pm_rd_en) pm_rdata <= 14'h2000 | {4'b0, pm_addr};

  typedef struct packed {
    logic            br;
    logic [PC_W-1:0] tgt;
    logic            rdy;
    logic            ev;
    logic [13:0]     ei;
    logic [PC_W-1:0] ea;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 10'd0,    1'b1, 1'b1, 14'h2000, 10'd1},    // R4 first fetch
    '{1'b0, 10'd0,    1'b1, 1'b1, 14'h2001, 10'd2},    // R4
    '{1'b0, 10'd0,    1'b0, 1'b1, 14'h2001, 10'd2},    // R7 stall
    '{1'b1, 10'd100,  1'b0, 1'b1, 14'h2001, 10'd2},    // R7 branch ignored
    '{1'b0, 10'd0,    1'b1, 1'b1, 14'h2002, 10'd3},    // R4
    '{1'b1, 10'd100,  1'b1, 1'b0, 14'h0000, 10'd100},  // R6 bubble
    '{1'b0, 10'd0,    1'b0, 1'b1, 14'h2064, 10'd101},  // R9 ready ignored
    '{1'b1, 10'd1023, 1'b1, 1'b0, 14'h0000, 10'd1023}, // R6
    '{1'b0, 10'd0,    1'b1, 1'b1, 14'h23FF, 10'd0},    // R5 wrap
    '{1'b0, 10'd0,    1'b1, 1'b1, 14'h2000, 10'd1},    // R4
    '{1'b1, 10'd5,    1'b1, 1'b0, 14'h0000, 10'd5},    // R6
    '{1'b1, 10'd9,    1'b1, 1'b1, 14'h2005, 10'd6},    // R9 branch ignored
    '{1'b1, 10'd8,    1'b1, 1'b0, 14'h0000, 10'd8},    // R6
    '{1'b0, 10'd0,    1'b1, 1'b1, 14'h2008, 10'd9}     // R6 target word
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic next_cycle(input logic br, input logic [PC_W-1:0] tgt, input logic rdy);
    while (!cyc_strobe) @(negedge clk);
    br_req = br; br_target = tgt; insn_ready = rdy;
    @(posedge clk); @(negedge clk);
    br_req = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pm_addr == '0, "R1", "reset pm_addr", 32'(pm_addr), 0);
    chk(insn == '0 && !insn_valid, "R1", "reset insn/valid", {insn, 1'b0, insn_valid}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      next_cycle(VEC[i].br, VEC[i].tgt, VEC[i].rdy);
      chk(insn == VEC[i].ei && insn_valid == VEC[i].ev && pm_addr == VEC[i].ea,
          "R4 R5 R6 R7 R9", $sformatf("vector %0d insn/valid/addr", i),
          {insn, 1'b0, insn_valid, pm_addr}, {VEC[i].ei, 1'b0, VEC[i].ev, VEC[i].ea});
    end

    // R8 and R3: insn and pm_addr hold over the clocks of one cycle
    begin
      logic [13:0] i0; logic [PC_W-1:0] a0; int bad; int rd;
      i0 = insn; a0 = pm_addr; bad = 0; rd = 0;
      for (int k = 0; k < 3; k++) begin
        if (pm_rd_en) rd++;
        @(negedge clk);
        if (insn != i0 || pm_addr != a0) bad++;
      end
      chk(bad == 0, "R8", "insn/addr changes inside cycle", 32'(bad), 0);
      chk(rd == 1, "R3", "read enables per cycle", 32'(rd), 1);
    end

    // R2: distance between strobes
    begin
      int gap; gap = 0;
      while (!cyc_strobe) @(negedge clk);
      @(negedge clk); gap = 1;
      while (!cyc_strobe) begin @(negedge clk); gap++; end
      chk(gap == 4, "R2", "strobe spacing", 32'(gap), 4);
    end

    // R1: mid-run reset, then first strobe on fourth clock after release
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(pm_addr == '0 && insn == '0 && !insn_valid, "R1", "mid-run reset state",
        {insn, 1'b0, insn_valid, pm_addr}, 0);
    rst_n = 1'b1;
    begin
      int c; c = 1;
      while (!cyc_strobe) begin @(negedge clk); c++; end
      chk(c == 4, "R2", "first strobe after reset", 32'(c), 4);
    end
    next_cycle(1'b0, '0, 1'b1);
    chk(insn == 14'h2000 && insn_valid && pm_addr == 10'd1, "R4", "first word after reset",
        {insn, 1'b0, insn_valid, pm_addr}, {14'h2000, 1'b0, 1'b1, 10'd1});

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule